// File: doc/BRIEF.md
# Infrared Serial Frame Unwrapper

This block sits behind the byte receiver of a slow asynchronous infrared link and turns the raw wrapped byte stream into bare packets. A frame on the wire opens with one or more begin flags (0xC0) and may be preceded by 0xFF filler. It closes with an end flag (0xC1), and any payload byte that collides with a control value is sent as 0x7D followed by the byte XOR 0x20. The unwrapper drops everything outside a frame, removes the flags and the escape prefix, and forwards only the restored payload together with the two check-sequence bytes. The check sequence itself is not verified here.

Every forwarded byte carries a live 12-bit packet count. The first byte of a packet is marked. The close of a packet produces a separate marker cycle that presents the final count and two error flags: one for a packet that outgrew a programmable limit, and one for a packet cut short by a begin flag that arrives before its end flag. The filter is active in the slow serial mode, or in any mode when a test enable is high. Otherwise bytes pass straight through.

Top module: `sir_deframer`

## Requirements
- R1: `flag_pair` always reads 16'hC1C0: begin flag 0xC0 in bits [7:0], end flag 0xC1 in bits [15:8].
- R2: While the filter is active and no frame is open, every input byte is dropped (out_valid stays low). A 0xC0 opens a frame. Further 0xC0 bytes before the first payload byte are dropped and do not close the frame.
- R3: Inside a frame, 0xC0 is the begin flag, 0xC1 is the end flag and 0x7D is the escape byte. A 0x7D is removed, and the byte after it that is neither flag is forwarded XORed with 0x20.
- R4: A 0xC1 in an open frame closes it. In the following cycle out_eop is 1 and out_valid is 0, with byte_cnt holding the number of bytes forwarded for that packet and err_len/err_bad holding its flags.
- R5: The first byte forwarded after a frame opens has out_sop = 1. No other forwarded byte has it.
- R6: byte_cnt (12 bits) rises by one with each forwarded byte, so it reads 1 on the start-of-packet byte. It returns to 0 two cycles after a begin flag is accepted unless a byte is forwarded in that cycle, and it can be read at any time.
- R7: A payload byte that arrives when byte_cnt already equals max_len (bits [11:0]) is not forwarded. byte_cnt holds and err_len is set until the next begin flag takes effect.
- R8: A 0xC0 arriving in an open frame after at least one payload byte produces an out_eop cycle with err_bad = 1 and the old count, then opens a new frame.
- R9: With both sir_mode and filt_test low, each valid input byte is forwarded unchanged without out_sop or out_eop, and byte_cnt does not advance. Either enable alone activates the filter.
- R10: Every output reflects the input byte sampled at the previous rising clock edge (one register stage).
- R11: After reset, out_valid, out_sop, out_eop, err_len, err_bad and byte_cnt are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte qualifier |
| in_byte | input | 8 | Received byte |
| sir_mode | input | 1 | Slow serial mode selected; enables the filter |
| filt_test | input | 1 | Enables the filter in any mode |
| max_len | input | 12 | Largest accepted packet length in bytes |
| out_valid | output | 1 | Forwarded byte present |
| out_byte | output | 8 | Forwarded (unescaped) byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Packet closed; count and flags are final |
| byte_cnt | output | 12 | Bytes forwarded in the current packet |
| err_len | output | 1 | Packet exceeded max_len |
| err_bad | output | 1 | Packet cut by a begin flag before its end flag |
| flag_pair | output | 16 | Fixed begin/end flag values |

## Verification
The count reset triggered by a begin flag takes effect one cycle later, so it can coincide with accepting the next payload byte or with an end flag. The stimulus provokes the first case with a begin flag followed directly by data, where byte_cnt must read 1 with out_sop. It provokes the second with 0xC0 0xC1 back to back, where the close marker must report a count of 0. A length-limit drop can also land on the same cycle as that reset when max_len is 0. Random streams rich in 0xC0, 0xC1 and 0x7D hit all of these cases repeatedly, and each cycle's outputs are compared with a reference model written from the requirements.

// File: rtl/sir_deframer_pkg.sv
package sir_deframer_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FLAG_BEGIN = 8'hC0;
  localparam logic [BYTE_W-1:0] FLAG_END   = 8'hC1;
  localparam logic [BYTE_W-1:0] ESC_BYTE   = 8'h7D;
  localparam logic [BYTE_W-1:0] ESC_XOR    = 8'h20;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_ESC  = 2'd2
  } frm_state_e;

  typedef struct packed {
    logic is_begin;
    logic is_end;
    logic is_esc;
  } byte_kind_t;
endpackage

// File: rtl/sir_byte_class.sv
module sir_byte_class
  import sir_deframer_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_i,
  output byte_kind_t        kind_o
);
  always_comb begin
    kind_o.is_begin = (byte_i == FLAG_BEGIN);
    kind_o.is_end   = (byte_i == FLAG_END);
    kind_o.is_esc   = (byte_i == ESC_BYTE);
  end
endmodule

// File: rtl/sir_frame_fsm.sv
module sir_frame_fsm
  import sir_deframer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  byte_kind_t        kind_i,
  output logic              pass_o,
  output logic [BYTE_W-1:0] pass_data_o,
  output logic              eop_o,
  output logic              bad_o,
  output logic              start_o
);
  frm_state_e state_q, state_d;
  logic       seen_q, seen_d;
  logic       restart_q, restart_d;

  always_comb begin
    state_d     = state_q;
    seen_d      = seen_q;
    restart_d   = 1'b0;
    pass_o      = 1'b0;
    pass_data_o = byte_i;
    eop_o       = 1'b0;
    bad_o       = 1'b0;
    if (!active_i) begin
      state_d = ST_IDLE;
      seen_d  = 1'b0;
    end else if (valid_i) begin
      if (state_q == ST_IDLE) begin
        if (kind_i.is_begin) begin
          state_d   = ST_OPEN;
          restart_d = 1'b1;
        end
      end else if (kind_i.is_begin) begin
        if (seen_q) begin
          eop_o = 1'b1;
          bad_o = 1'b1;
        end
        state_d   = ST_OPEN;
        seen_d    = 1'b0;
        restart_d = 1'b1;
      end else if (kind_i.is_end) begin
        eop_o   = 1'b1;
        state_d = ST_IDLE;
        seen_d  = 1'b0;
      end else if (state_q == ST_OPEN && kind_i.is_esc) begin
        state_d = ST_ESC;
      end else begin
        pass_o  = 1'b1;
        seen_d  = 1'b1;
        state_d = ST_OPEN;
        if (state_q == ST_ESC) pass_data_o = byte_i ^ ESC_XOR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      seen_q    <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      seen_q    <= seen_d;
      restart_q <= restart_d;
    end
  end

  assign start_o = restart_q;

  // R2: no byte is forwarded unless a frame has been opened
  p_no_pass_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (state_q != ST_IDLE));

  // R8: a cut frame always restarts the count in the following cycle
  p_bad_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_o |=> start_o);
endmodule

// File: rtl/sir_len_counter.sv
module sir_len_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pass_i,
  input  logic             bad_i,
  input  logic [CNT_W-1:0] max_len_i,
  output logic             accept_o,
  output logic             first_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_len_o,
  output logic             err_bad_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             el_q, el_d, eb_q, eb_d;

  always_comb begin
    base     = start_i ? '0 : cnt_q;
    accept_o = pass_i && (base < max_len_i);
    first_o  = (base == '0);
    cnt_d    = accept_o ? (base + CNT_ONE) : base;
    el_d     = (start_i ? 1'b0 : el_q) | (pass_i & ~accept_o);
    eb_d     = (start_i ? 1'b0 : eb_q) | bad_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      el_q  <= 1'b0;
      eb_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      el_q  <= el_d;
      eb_q  <= eb_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign err_len_o = el_q;
  assign err_bad_o = eb_q;

  // R6: each accepted byte in a running packet adds exactly one
  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && !start_i) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R7: a byte at the limit is refused, count frozen, length flag raised
  p_len_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_i && !start_i && (cnt_q >= max_len_i)) |=> (el_q && (cnt_q == $past(cnt_q))));
endmodule

// File: rtl/sir_deframer.sv
module sir_deframer
  import sir_deframer_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             sir_mode,
  input  logic             filt_test,
  input  logic [CNT_W-1:0] max_len,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_sop,
  output logic             out_eop,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             err_len,
  output logic             err_bad,
  output logic [15:0]      flag_pair
);
  logic       rst_meta_q, rst_sync_q;
  logic       active;
  byte_kind_t kind;
  logic       pass, eop, bad, start, accept, first;
  logic [7:0] pass_data;
  logic       ov_q, ov_d, sop_q, sop_d, eop_q, eop_d;
  logic [7:0] ob_q, ob_d;
  logic       ob_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign active = sir_mode | filt_test;

  sir_byte_class u_class (
    .byte_i (in_byte),
    .kind_o (kind)
  );

  sir_frame_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .active_i    (active),
    .valid_i     (in_valid),
    .byte_i      (in_byte),
    .kind_i      (kind),
    .pass_o      (pass),
    .pass_data_o (pass_data),
    .eop_o       (eop),
    .bad_o       (bad),
    .start_o     (start)
  );

  sir_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .start_i   (start),
    .pass_i    (pass),
    .bad_i     (bad),
    .max_len_i (max_len),
    .accept_o  (accept),
    .first_o   (first),
    .cnt_o     (byte_cnt),
    .err_len_o (err_len),
    .err_bad_o (err_bad)
  );

  always_comb begin
    ov_d  = active ? accept : in_valid;
    ob_d  = active ? pass_data : in_byte;
    ob_en = ov_d;
    sop_d = active & accept & first;
    eop_d = active & eop;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      ov_q  <= 1'b0;
      sop_q <= 1'b0;
      eop_q <= 1'b0;
      ob_q  <= '0;
    end else begin
      ov_q  <= ov_d;
      sop_q <= sop_d;
      eop_q <= eop_d;
      if (ob_en) ob_q <= ob_d;
    end
  end

  assign out_valid = ov_q;
  assign out_byte  = ob_q;
  assign out_sop   = sop_q;
  assign out_eop   = eop_q;
  assign flag_pair = {FLAG_END, FLAG_BEGIN};

  // R5: a start marker only ever rides on a forwarded byte
  p_sop_has_data_r5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_sop |-> out_valid);

  // R4: the close marker occupies its own cycle
  p_eop_alone_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_eop |-> !out_valid);

  // R8: the cut-frame flag is only presented together with a close marker
  p_bad_on_eop_r8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    err_bad |-> out_eop);

  // R6: a start-of-packet byte always reports a count of one
  p_sop_count_r6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    out_sop |-> (byte_cnt == {{(CNT_W-1){1'b0}}, 1'b1}));
endmodule

// File: tb/sir_deframer_tb.sv
module sir_deframer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        sir_mode, filt_test;
  logic [11:0] max_len;
  logic        out_valid, out_sop, out_eop, err_len, err_bad;
  logic [7:0]  out_byte;
  logic [11:0] byte_cnt;
  logic [15:0] flag_pair;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  int          m_state;
  bit          m_seen, m_restart, m_el, m_eb;
  logic [11:0] m_cnt;
  // expected outputs
  bit          e_valid, e_sop, e_eop;
  logic [7:0]  e_byte;
  string       tag;

  sir_deframer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .sir_mode(sir_mode), .filt_test(filt_test), .max_len(max_len),
    .out_valid(out_valid), .out_byte(out_byte), .out_sop(out_sop),
    .out_eop(out_eop), .byte_cnt(byte_cnt), .err_len(err_len),
    .err_bad(err_bad), .flag_pair(flag_pair)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // reference behaviour built from the requirements
  task automatic m_step(input bit v, input logic [7:0] b, input bit act, input logic [11:0] ml);
    bit start, pass, esc, eop, bad;
    logic [11:0] base;
    logic [7:0] pd;
    start = m_restart;
    m_restart = 1'b0;
    base = start ? 12'd0 : m_cnt;
    if (start) begin m_el = 1'b0; m_eb = 1'b0; end
    pass = 0; esc = 0; eop = 0; bad = 0; pd = b;
    e_valid = 0; e_sop = 0; tag = "R2";
    if (!act) begin
      m_state = 0; m_seen = 0; e_valid = v; tag = "R9";
    end else if (v) begin
      if (m_state == 0) begin
        if (b == 8'hC0) begin m_state = 1; m_restart = 1; end
      end else if (b == 8'hC0) begin
        if (m_seen) begin eop = 1; bad = 1; end
        m_state = 1; m_seen = 0; m_restart = 1;
      end else if (b == 8'hC1) begin
        eop = 1; m_state = 0; m_seen = 0;
      end else if (m_state == 1 && b == 8'h7D) begin
        m_state = 2;
      end else begin
        pass = 1; m_seen = 1;
        if (m_state == 2) begin pd = b ^ 8'h20; esc = 1; end
        m_state = 1;
      end
    end
    if (pass) begin
      if (base < ml) begin
        e_valid = 1; e_sop = (base == 0); base = base + 12'd1;
        tag = e_sop ? "R5" : (esc ? "R3" : "R6");
      end else begin
        m_el = 1; tag = "R7";
      end
    end
    if (bad) m_eb = 1;
    if (eop) tag = bad ? "R8" : "R4";
    e_eop = eop; e_byte = pd; m_cnt = base;
  endtask

  // one cycle: drive away from the edge, let one register stage pass (R10), compare
  task automatic cycle(input bit v, input logic [7:0] b, input bit sm, input bit ft, input logic [11:0] ml);
    bit ok;
    in_valid = v; in_byte = b; sir_mode = sm; filt_test = ft; max_len = ml;
    m_step(v, b, sm | ft, ml);
    @(posedge clk);
    #(CLK_PERIOD/4);
    ok = (out_valid == e_valid) && (out_sop == e_sop) && (out_eop == e_eop) &&
         (byte_cnt == m_cnt) && (err_len == m_el) && (err_bad == m_eb) &&
         (!e_valid || out_byte == e_byte);
    check(ok, tag,
          {out_valid, out_sop, out_eop, err_len, err_bad, out_byte, byte_cnt, 3'b0},
          {e_valid, e_sop, e_eop, m_el, m_eb, e_byte, m_cnt, 3'b0});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [11:0] lim;
    bit sm, ft;
    seed = $urandom(32'h5EED_1234);
    rst_n = 1'b0; in_valid = 0; in_byte = 0; sir_mode = 1; filt_test = 0; max_len = 12'd4095;
    m_state = 0; m_seen = 0; m_restart = 0; m_el = 0; m_eb = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R11: reset state
    check({out_valid, out_sop, out_eop, err_len, err_bad} == 5'b0 && byte_cnt == 0,
          "R11", {out_valid, out_sop, out_eop, err_len, err_bad, byte_cnt}, 32'h0);
    // R1: fixed flag pair
    check(flag_pair == 16'hC1C0, "R1", flag_pair, 32'hC1C0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);

    // directed: filler, repeated begin, escaped byte, close
    cycle(1, 8'hFF, 1, 0, 12'd4095);
    cycle(1, 8'h41, 1, 0, 12'd4095);
    cycle(1, 8'hC0, 1, 0, 12'd4095);
    cycle(1, 8'hC0, 1, 0, 12'd4095);
    cycle(1, 8'h11, 1, 0, 12'd4095);
    check(out_sop && byte_cnt == 12'd1, "R5", {out_sop, byte_cnt}, {1'b1, 12'd1});
    cycle(1, 8'h7D, 1, 0, 12'd4095);
    cycle(1, 8'h5D, 1, 0, 12'd4095);
    check(out_byte == 8'h7D, "R3", out_byte, 8'h7D);
    cycle(1, 8'h22, 1, 0, 12'd4095);
    cycle(1, 8'hC1, 1, 0, 12'd4095);
    check(out_eop && byte_cnt == 12'd3 && !err_bad, "R4", byte_cnt, 12'd3);
    // same-cycle corner: begin directly followed by end, count must be 0
    cycle(1, 8'hC0, 0, 1, 12'd4095);
    cycle(1, 8'hC1, 0, 1, 12'd4095);
    check(out_eop && byte_cnt == 12'd0, "R6", byte_cnt, 12'd0);
    // cut frame
    cycle(1, 8'hC0, 1, 0, 12'd2);
    cycle(1, 8'h01, 1, 0, 12'd2);
    cycle(1, 8'h02, 1, 0, 12'd2);
    cycle(1, 8'h03, 1, 0, 12'd2);
    check(err_len && byte_cnt == 12'd2, "R7", {err_len, byte_cnt}, {1'b1, 12'd2});
    cycle(1, 8'hC0, 1, 0, 12'd2);
    check(out_eop && err_bad, "R8", {out_eop, err_bad}, 2'b11);
    cycle(1, 8'hC1, 1, 0, 12'd2);
    // bypass
    cycle(1, 8'hC0, 0, 0, 12'd2);
    check(out_valid && out_byte == 8'hC0 && !out_sop, "R9", out_byte, 8'hC0);

    // constrained random streams
    sm = 1; ft = 0; lim = 12'd4095;
    for (int i = 0; i < 6000; i++) begin
      int unsigned r;
      logic [7:0] b;
      if (i % 400 == 0) begin
        case ($urandom % 6)
          0: lim = 12'd0;
          1: lim = 12'd1;
          2: lim = 12'd3;
          3: lim = 12'd6;
          4: lim = 12'd12;
          default: lim = 12'd4095;
        endcase
        case ($urandom % 5)
          0: begin sm = 0; ft = 0; end
          1: begin sm = 0; ft = 1; end
          default: begin sm = 1; ft = 0; end
        endcase
      end
      r = $urandom % 16;
      if (r < 3) b = 8'hC0;
      else if (r == 3) b = 8'hC1;
      else if (r < 6) b = 8'h7D;
      else if (r == 6) b = 8'hFF;
      else b = 8'($urandom);
      cycle(($urandom % 100) < 85, b, sm, ft, lim);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule